// File: doc/BRIEF.md
# ATM Transmit Cell Processor

This block sits in the outbound path of an ATM-over-DS3 transmitter and works on 53-octet cells one octet per transfer. The stream enters with a start-of-cell strobe and a flag that marks the cell as idle or valid. The block changes four things. It may overwrite the GFC nibble of valid cells with bits that arrive on a serial pin. It may replace the fifth octet with a freshly computed HEC, with or without the coset. It may scramble the 48 payload octets with a self-synchronizing x^43+1 scrambler. Before it replaces the fifth octet of a valid cell, it compares that octet against an expected integrity tag. A mismatch sets a sticky status bit, which clears when the control register is read, and can also raise an interrupt.

Both stream ports follow valid/ready rules and the path has no latency. An octet moves when `in_valid` and `out_ready` are both high in the same clock cycle. `in_ready` follows `out_ready`, and `out_valid` follows `in_valid`. When back-pressure holds a transfer off, none of the internal state moves, so the output octet stays fixed for as long as the input stays fixed. A single 8-bit control register holds the configuration and the status bit.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: An octet transfers exactly when in_valid and out_ready are both high, with in_ready = out_ready and out_valid = in_valid. While out_ready is low, no internal state advances.
- R2: After reset the control register reads 0x1F. The bits are: bit0 scramble enable, bit1 coset enable, bit2 HEC insert for valid cells, bit3 HEC insert for idle cells, bit4 constant-tag select, bit5 GFC insert enable, bit6 interrupt enable, bit7 integrity status. Bit7 is read-only.
- R3: In a valid cell with bit2 set, octet 5 (index 4) is output as the CRC-8 (generator x^8+x^2+x+1, initial value 0, MSB first) of output octets 1 to 4. With bit2 clear, octet 5 passes through unchanged.
- R4: Idle cells get the same HEC treatment as valid cells, but under bit3.
- R5: When bit1 is set, the inserted HEC is XORed with 0x55.
- R6: When bit0 is set, the payload octets (index 5 to 52) are scrambled MSB first as s = d XOR s delayed by 43 bits. The scrambler history starts at zero and advances only on scrambled octets. Header octets are never scrambled. When bit0 is clear, the payload passes through unchanged.
- R7: At each transfer of octets 1 to 4 of a cell, gfc_serial is sampled MSB first. Those four bits replace bits 7:4 of octet 1 of the next valid cell when bit5 is set. Before any complete cell has passed, the nibble is 0.
- R8: Octet 5 of each valid cell is checked before the HEC replaces it. The expected value is 0x55 when bit4 is set. When bit4 is clear, the expected value alternates 0x55, 0xAA, 0x55 and so on, starting at 0x55 after reset and stepping once per valid cell. Idle cells are never checked and do not step the sequence.
- R9: A mismatch sets status bit7. A register read returns the value the register held before that cycle and clears bit7, unless a mismatch occurs in the same cycle, in which case bit7 stays set.
- R10: irq equals the status bit ANDed with bit6, and once high it stays high until a read or a write.
- R11: in_sop restarts the octet count at index 0, even in the middle of a cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input octet valid |
| in_ready | output | 1 | Block can accept an octet |
| in_data | input | 8 | Input octet |
| in_sop | input | 1 | First octet of a cell |
| in_idle | input | 1 | Cell is idle (sampled with the first octet) |
| out_valid | output | 1 | Output octet valid |
| out_ready | input | 1 | Downstream can accept an octet |
| out_data | output | 8 | Processed octet |
| out_sop | output | 1 | First octet of a cell, forwarded |
| out_idle | output | 1 | Idle flag, forwarded |
| gfc_serial | input | 1 | Serial GFC bits |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe (clears status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register contents |
| irq | output | 1 | Integrity interrupt |

## Verification
Two events can fall in the same cycle: a status-clearing register read and the integrity check of a mismatching fifth octet. The bench raises reg_rd in the same cycle that it transfers a wrong tag. It then requires reg_rdata to show the earlier clear status, and a later read to show bit7 set. It also holds out_ready low in the middle of a cell and checks the payload that follows, so any state that moves during a stall shows up as scrambled-octet errors.

// File: rtl/atm_tcp_pkg.sv
package atm_tcp_pkg;
  localparam int OCT_W = 8;
  localparam int CELL_OCTETS = 53;
  localparam int HEC_POS = 4;
  localparam int GFC_BITS = 4;
  localparam int SCR_LAG = 43;
  localparam logic [OCT_W-1:0] HEC_POLY = 8'h07;
  localparam logic [OCT_W-1:0] COSET_VAL = 8'h55;
  localparam logic [OCT_W-1:0] TAG_EVEN = 8'h55;
  localparam logic [OCT_W-1:0] TAG_ODD = 8'hAA;
  localparam logic [OCT_W-1:0] CTL_RESET = 8'h1F;

  // control register layout, bit7 down to bit0
  typedef struct packed {
    logic status;
    logic irq_en;
    logic gfc_en;
    logic pat_const;
    logic hec_idle_en;
    logic hec_valid_en;
    logic coset_en;
    logic scr_en;
  } ctl_t;
endpackage

// File: rtl/atm_hec_step.sv
module atm_hec_step #(
  parameter int W = atm_tcp_pkg::OCT_W,
  parameter logic [W-1:0] POLY = atm_tcp_pkg::HEC_POLY
) (
  input  logic [W-1:0] crc_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] c;
  always_comb begin
    c = crc_i;
    for (int i = W - 1; i >= 0; i--) begin
      if (c[W-1] ^ byte_i[i]) c = {c[W-2:0], 1'b0} ^ POLY;
      else c = {c[W-2:0], 1'b0};
    end
    crc_o = c;
  end
endmodule

// File: rtl/atm_x43_scrambler.sv
module atm_x43_scrambler #(
  parameter int W = atm_tcp_pkg::OCT_W,
  parameter int LAG = atm_tcp_pkg::SCR_LAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] byte_o
);
  // hist[0] is the most recent scrambled bit
  logic [LAG-1:0] hist;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign byte_o[W-1-i] = byte_i[W-1-i] ^ hist[LAG-1-i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else if (advance) hist <= {hist[LAG-W-1:0], byte_o};
  end

  a_r6_hist_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(hist));
endmodule

// File: rtl/atm_tcp_regs.sv
module atm_tcp_regs
  import atm_tcp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [OCT_W-1:0] wdata,
  input  logic             set_err,
  output ctl_t             ctl_o,
  output logic [OCT_W-1:0] rdata
);
  logic [OCT_W-2:0] bits_q;
  logic             st_q;
  logic             unused_wbit;

  assign unused_wbit = wdata[OCT_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q <= CTL_RESET[OCT_W-2:0];
      st_q   <= 1'b0;
    end else begin
      if (wr) bits_q <= wdata[OCT_W-2:0];
      if (set_err) st_q <= 1'b1;
      else if (rd) st_q <= 1'b0;
    end
  end

  assign rdata = {st_q, bits_q};
  assign ctl_o = ctl_t'({st_q, bits_q});

  a_r9_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |=> st_q);
  a_r9_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    st_q && !rd |=> st_q);
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !set_err |=> !st_q);
endmodule

// File: rtl/atm_tx_cell_proc.sv
module atm_tx_cell_proc
  import atm_tcp_pkg::*;
#(
  parameter int CELL_LEN = CELL_OCTETS,
  parameter int HEC_AT = HEC_POS,
  parameter int GFC_W = GFC_BITS,
  parameter int LAG = SCR_LAG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OCT_W-1:0] in_data,
  input  logic             in_sop,
  input  logic             in_idle,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OCT_W-1:0] out_data,
  output logic             out_sop,
  output logic             out_idle,
  input  logic             gfc_serial,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [OCT_W-1:0] reg_wdata,
  output logic [OCT_W-1:0] reg_rdata,
  output logic             irq
);
  localparam int IDX_W = $clog2(CELL_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_LEN - 1);
  localparam logic [IDX_W-1:0] HEC_IDX = IDX_W'(HEC_AT);
  localparam logic [IDX_W-1:0] GFC_END = IDX_W'(GFC_W);

  ctl_t             ctl;
  logic             xfer, cell_idle, hec_on, chk, mismatch, scr_adv;
  logic [IDX_W-1:0] cnt_q, idx;
  logic             idle_q, alt_q;
  logic [OCT_W-1:0] crc_q, crc_base, crc_nxt, hdr_byte, hec_val, tag_exp, scr_byte;
  logic [GFC_W-1:0] gfc_sh_q, gfc_hold_q;

  assign xfer      = in_valid & out_ready;
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign out_sop   = in_sop;
  assign out_idle  = in_idle;

  assign idx       = in_sop ? '0 : cnt_q;
  assign cell_idle = (idx == '0) ? in_idle : idle_q;
  assign hec_on    = cell_idle ? ctl.hec_idle_en : ctl.hec_valid_en;

  always_comb begin
    hdr_byte = in_data;
    if (idx == '0 && ctl.gfc_en && !cell_idle) hdr_byte[OCT_W-1 -: GFC_W] = gfc_hold_q;
  end

  assign crc_base = (idx == '0) ? '0 : crc_q;
  atm_hec_step #(.W(OCT_W), .POLY(HEC_POLY)) u_hec (
    .crc_i(crc_base), .byte_i(hdr_byte), .crc_o(crc_nxt));
  assign hec_val = crc_q ^ (ctl.coset_en ? COSET_VAL : '0);

  assign scr_adv = xfer && (idx > HEC_IDX) && ctl.scr_en;
  atm_x43_scrambler #(.W(OCT_W), .LAG(LAG)) u_scr (
    .clk(clk), .rst_n(rst_n), .advance(scr_adv), .byte_i(in_data), .byte_o(scr_byte));

  always_comb begin
    if (idx < HEC_IDX) out_data = hdr_byte;
    else if (idx == HEC_IDX) out_data = hec_on ? hec_val : in_data;
    else out_data = ctl.scr_en ? scr_byte : in_data;
  end

  // integrity tag check sees the incoming octet, before HEC substitution
  assign tag_exp  = (ctl.pat_const || !alt_q) ? TAG_EVEN : TAG_ODD;
  assign chk      = xfer && (idx == HEC_IDX) && !cell_idle;
  assign mismatch = chk && (in_data != tag_exp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      idle_q     <= 1'b0;
      alt_q      <= 1'b0;
      crc_q      <= '0;
      gfc_sh_q   <= '0;
      gfc_hold_q <= '0;
    end else if (xfer) begin
      cnt_q <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
      if (idx == '0) idle_q <= in_idle;
      if (idx < HEC_IDX) crc_q <= crc_nxt;
      if (idx < GFC_END) gfc_sh_q <= {gfc_sh_q[GFC_W-2:0], gfc_serial};
      if (idx == LAST_IDX) gfc_hold_q <= gfc_sh_q;
      if (chk) alt_q <= ~alt_q;
    end
  end

  atm_tcp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
    .set_err(mismatch), .ctl_o(ctl), .rdata(reg_rdata));

  assign irq = ctl.status & ctl.irq_en;

  a_r11_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX);
  a_r1_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> $stable(cnt_q) && $stable(crc_q) && $stable(alt_q));
  a_r8_alt_steps: assert property (@(posedge clk) disable iff (!rst_n)
    chk |=> alt_q != $past(alt_q));
  a_r8_idle_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && idx == HEC_IDX && cell_idle |=> $stable(alt_q));
  a_r10_irq_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !reg_rd && !reg_wr |=> irq);
  a_r6_header_clear: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && idx != '0 && idx < HEC_IDX |-> out_data == in_data);
endmodule

// File: tb/atm_tx_cell_proc_test.sv
module atm_tx_cell_proc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic in_valid = 0, in_ready, in_sop = 0, in_idle = 0;
  logic [7:0] in_data = 0, out_data, reg_wdata = 0, reg_rdata;
  logic out_valid, out_ready = 1, out_sop, out_idle, gfc_serial = 0;
  logic reg_wr = 0, reg_rd = 0, irq;

  atm_tx_cell_proc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_idle(in_idle),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_idle(out_idle), .gfc_serial(gfc_serial),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  int n_chk = 0, n_fail = 0;
  // reference state, built from the requirements
  int m_idx = 0;
  logic m_idle = 0, m_alt = 0, m_st = 0;
  logic [7:0] m_crc = 0, m_ctl = 8'h1F;
  logic [42:0] m_hist = '0;
  logic [3:0] m_gsh = 0, m_ghold = 0;
  int cell_err = 0, stall_err = 0;
  logic [7:0] bad_act, bad_exp;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = {c ^ d, 8'h00};
    for (int b = 15; b >= 8; b--) if (r[b]) r[b-:9] = r[b-:9] ^ 9'h107;
    return r[7:0];
  endfunction

  task automatic push(input logic [7:0] d, input logic sop, input logic idl,
                      input logic gb, input bit rd_now, input bit stall);
    logic [7:0] exp, hb, sb;
    logic [42:0] h;
    int ix;
    logic ci, mis;
    @(negedge clk);
    in_valid = 1; in_data = d; in_sop = sop; in_idle = idl; gfc_serial = gb; reg_rd = rd_now;
    ix = sop ? 0 : m_idx;
    ci = (ix == 0) ? idl : m_idle;
    hb = d;
    if (ix == 0 && m_ctl[5] && !ci) hb[7:4] = m_ghold;
    h = m_hist;
    sb = d;
    if (ix > 4 && m_ctl[0])
      for (int b = 7; b >= 0; b--) begin
        sb[b] = d[b] ^ h[42];
        h = {h[41:0], sb[b]};
      end
    if (ix < 4) exp = hb;
    else if (ix == 4) exp = ((ci ? m_ctl[3] : m_ctl[2])) ? (m_crc ^ (m_ctl[1] ? 8'h55 : 8'h00)) : d;
    else exp = sb;
    if (stall) begin
      out_ready = 0;
      #1;
      if (in_ready !== 1'b0 || out_valid !== 1'b1) stall_err++;
      @(negedge clk);
      out_ready = 1;
    end
    #1;
    if (out_data !== exp) begin
      if (cell_err == 0) begin bad_act = out_data; bad_exp = exp; end
      cell_err++;
    end
    if (rd_now) check(reg_rdata[7] === m_st, "R9 read in mismatch cycle shows old status", reg_rdata[7], m_st);
    mis = 0;
    if (ix < 4) begin m_crc = crc8((ix == 0) ? 8'h00 : m_crc, hb); m_gsh = {m_gsh[2:0], gb}; end
    if (ix == 52) m_ghold = m_gsh;
    if (ix == 0) m_idle = idl;
    if (ix == 4 && !ci) begin
      mis = (d != ((m_ctl[4] || !m_alt) ? 8'h55 : 8'hAA));
      m_alt = ~m_alt;
    end
    if (mis) m_st = 1; else if (rd_now) m_st = 0;
    if (ix > 4 && m_ctl[0]) m_hist = h;
    m_idx = (ix == 52) ? 0 : ix + 1;
  endtask

  task automatic send_cell(input logic [31:0] hdr, input logic [7:0] tag, input logic idl,
                           input logic [3:0] nib, input int seed, input int len,
                           input int stall_mod, input bit rd_at_tag);
    cell_err = 0;
    for (int k = 0; k < len; k++) begin
      logic [7:0] d;
      if (k < 4) d = hdr[31-8*k -: 8];
      else if (k == 4) d = tag;
      else d = 8'((seed * 37 + k * 11) ^ (k << 3));
      push(d, k == 0, idl, (k < 4) ? nib[3-k] : 1'b0, rd_at_tag && k == 4,
           stall_mod > 0 && (k % stall_mod) == 2);
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; reg_rd = 0;
  endtask

  task automatic reg_write(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1; reg_wdata = v;
    @(posedge clk);
    #1 reg_wr = 0;
    m_ctl = v;
  endtask

  task automatic reg_read(output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1;
    #1 v = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 0;
    m_st = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check(irq === 1'b0, "R10 irq low after reset", irq, 0);
    reg_read(v);
    check(v === 8'h1F, "R2 reset register value", v, 8'h1F);
  endtask

  task automatic t_valid_cells;
    logic [7:0] v;
    send_cell(32'h0012_3450, 8'h55, 0, 4'h0, 1, 53, 0, 0);
    check(cell_err == 0, "R3 R5 R6 valid cell default config", bad_act, bad_exp);
    send_cell(32'hA5F0_0C3E, 8'h55, 0, 4'h0, 2, 53, 0, 0);
    check(cell_err == 0, "R6 scrambler continues across cells", bad_act, bad_exp);
    reg_read(v);
    check(v[7] === 1'b0, "R8 correct tag checked before HEC overwrite", v[7], 0);
  endtask

  task automatic t_backpressure;
    stall_err = 0;
    send_cell(32'h1122_3344, 8'h55, 0, 4'h0, 3, 53, 5, 0);
    check(stall_err == 0, "R1 in_ready follows out_ready during stall", stall_err, 0);
    check(cell_err == 0, "R1 no state advance during stall", bad_act, bad_exp);
  endtask

  task automatic t_idle;
    logic [7:0] v;
    send_cell(32'h0000_0001, 8'h52, 1, 4'h0, 4, 53, 0, 0);
    check(cell_err == 0, "R4 idle cell HEC inserted", bad_act, bad_exp);
    reg_write(8'h17);
    send_cell(32'h0000_0001, 8'h99, 1, 4'h0, 5, 53, 0, 0);
    check(cell_err == 0, "R4 idle HEC off passes octet 5", bad_act, bad_exp);
    reg_read(v);
    check(v[7] === 1'b0, "R8 idle cell tag not checked", v[7], 0);
  endtask

  task automatic t_config_variants;
    reg_write(8'h1C);
    send_cell(32'h0A0B_0C0D, 8'h55, 0, 4'h0, 6, 53, 0, 0);
    check(cell_err == 0, "R5 R6 no coset, no scrambling", bad_act, bad_exp);
    reg_write(8'h1B);
    send_cell(32'h0A0B_0C0D, 8'h55, 0, 4'h0, 7, 53, 0, 0);
    check(cell_err == 0, "R3 valid HEC off passes octet 5", bad_act, bad_exp);
    reg_write(8'h1F);
  endtask

  task automatic t_gfc;
    reg_write(8'h3F);
    send_cell(32'h0123_4567, 8'h55, 0, 4'hB, 8, 53, 0, 0);
    check(cell_err == 0, "R7 GFC from earlier cells", bad_act, bad_exp);
    send_cell(32'hF123_4567, 8'h55, 0, 4'h6, 9, 53, 0, 0);
    check(cell_err == 0, "R7 GFC nibble 0xB applied", bad_act, bad_exp);
    send_cell(32'h0000_0001, 8'h55, 1, 4'h3, 10, 53, 0, 0);
    check(cell_err == 0, "R7 idle cell keeps its header", bad_act, bad_exp);
    send_cell(32'h7777_7777, 8'h55, 0, 4'h0, 11, 53, 0, 0);
    check(cell_err == 0, "R7 nibble from idle cell period", bad_act, bad_exp);
    reg_write(8'h1F);
  endtask

  task automatic t_alternate;
    logic [7:0] v;
    reg_write(8'h0F);
    for (int c = 0; c < 3; c++) begin
      send_cell(32'h0102_0304, m_alt ? 8'hAA : 8'h55, 0, 4'h0, 12 + c, 53, 0, 0);
      send_cell(32'h0000_0001, 8'h00, 1, 4'h0, 20 + c, 53, 0, 0);
    end
    reg_read(v);
    check(v[7] === 1'b0, "R8 alternating tag accepted", v[7], 0);
    send_cell(32'h0102_0304, m_alt ? 8'h55 : 8'hAA, 0, 4'h0, 30, 53, 0, 0);
    check(irq === 1'b0, "R10 irq masked while disabled", irq, 0);
    reg_read(v);
    check(v[7] === 1'b1, "R9 mismatch sets status", v[7], 1);
    reg_read(v);
    check(v[7] === 1'b0, "R9 read clears status", v[7], 0);
    reg_write(8'h1F);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    reg_write(8'h5F);
    send_cell(32'h0102_0304, 8'h54, 0, 4'h0, 31, 53, 0, 0);
    check(irq === 1'b1, "R10 irq on mismatch", irq, 1);
    repeat (3) @(negedge clk);
    check(irq === 1'b1, "R10 irq held", irq, 1);
    reg_read(v);
    #1 check(irq === 1'b0, "R10 irq cleared by read", irq, 0);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    send_cell(32'h0102_0304, 8'h00, 0, 4'h0, 32, 53, 0, 1);
    reg_read(v);
    check(v[7] === 1'b1, "R9 set wins over clearing read", v[7], 1);
    reg_write(8'h1F);
  endtask

  task automatic t_resync;
    send_cell(32'hDEAD_BEEF, 8'h55, 0, 4'h0, 33, 10, 0, 0);
    send_cell(32'h0102_0304, 8'h55, 0, 4'h0, 34, 53, 0, 0);
    check(cell_err == 0, "R11 sop restarts mid-cell", bad_act, bad_exp);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_valid_cells();
    t_backpressure();
    t_idle();
    t_config_variants();
    t_gfc();
    t_alternate();
    t_irq();
    t_collide();
    t_resync();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule